// File: doc/BRIEF.md
# Horizontal Two-Phase Shift Clock Generator

This block produces the horizontal drive for one display line of a panel whose dots sit in a delta pattern. Each line begins with a one-cycle `lineStart` strobe. The block then emits a single horizontal start pulse, followed by a burst of complementary shift clocks `hClkA` and `hClkB`. The block runs from a clock at twice the shift-clock rate, so one `clk` cycle is one half of a shift-clock period (a "tick").

The aspect input selects how many shift-clock periods a line carries: more for the wide picture, fewer for the narrow one. The rows of the delta pattern are offset from one another. To follow that offset, every second line starts one tick (half a shift-clock period) later than its neighbour.

A line-parity flag toggles on every strobe. It selects the delay for the line and is also output as the polarity for line-by-line inversion of the video and side-black signals. The aspect and scan-direction inputs are captured at the strobe and held for the whole line.

Top module: `hdrv_clkgen`

## Requirements
- R1: After reset `hStart`=0, `hClkA`=0, `hClkB`=1, `linePolarity`=0, `scanRight`=0 and `aspectWide`=0.
- R2: `hClkB` is always the inverse of `hClkA`.
- R3: With `wideMode`=1 captured at the strobe, the line carries exactly WIDE_PULSES (default 357) rising edges of `hClkA`.
- R4: With `wideMode`=0 captured at the strobe, the line carries exactly NARROW_PULSES (default 268) rising edges of `hClkA`.
- R5: `hStart` is high for exactly one cycle, and `hClkA` rises in the very next cycle. On an even line, with the strobe sampled at edge E0, `hStart` is high after E1 and `hClkA` is high after E2, E4, and so on up to E(2N). Each pulse is one cycle high and one cycle low.
- R6: On a line where `linePolarity`=1 the whole R5 sequence occurs one cycle later than on a line where `linePolarity`=0.
- R7: `linePolarity` inverts at every strobe, taking its new value in the cycle after the strobe. The first line after reset therefore has polarity 1.
- R8: `scanRight` (1 = right scan, 0 = left scan) and `aspectWide` take the `rightScan` and `wideMode` values sampled at the strobe. Every combination is accepted.
- R9: Changes to `wideMode` or `rightScan` between strobes have no effect on the pulse count, `scanRight` or `aspectWide` until the next strobe.
- R10: Outside the active window (before `hStart`, after the last pulse, and with no line started) `hStart`=0, `hClkA`=0 and `hClkB`=1.
- R11: A strobe arriving during an active line abandons that line and starts a new one under R5 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the shift-clock rate |
| rstN | input | 1 | Active-low synchronous reset |
| lineStart | input | 1 | One-cycle line strobe |
| wideMode | input | 1 | Aspect select: 1 wide, 0 narrow |
| rightScan | input | 1 | Scan direction: 1 right, 0 left |
| hStart | output | 1 | Horizontal start pulse |
| hClkA | output | 1 | Shift clock, first phase |
| hClkB | output | 1 | Shift clock, inverse phase |
| linePolarity | output | 1 | Line parity / video inversion flag |
| scanRight | output | 1 | Captured scan direction |
| aspectWide | output | 1 | Captured aspect mode |

## Verification
A wrong tick counter shows up as a pulse burst that is too long or too short, or as a start pulse that lands in the wrong cycle. This is visible at `hClkA` within one line. A parity register that fails to toggle shows at once on `linePolarity`, and at the next line as a start position that does not move by one cycle. Mode latches that leak changes from the inputs would change `aspectWide` or `scanRight` in the cycle after the input moves, well before the next strobe.

// File: rtl/hdrv_pkg.sv
package hdrv_pkg;
  typedef struct packed {
    logic launch;    // raise start pulse next cycle
    logic clkHigh;   // drive shift clock high next cycle
    logic oddLine;   // current line parity
    logic rightLat;  // captured scan direction
    logic wideLat;   // captured aspect mode
  } hdrvStrobe_t;
endpackage

// File: rtl/hdrv_ctrl.sv
module hdrv_ctrl #(
  parameter int WIDE_PULSES   = 357,
  parameter int NARROW_PULSES = 268
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineStart,
  input  logic wideMode,
  input  logic rightScan,
  output hdrv_pkg::hdrvStrobe_t strobe
);
  localparam int MAX_PULSES = (WIDE_PULSES > NARROW_PULSES) ? WIDE_PULSES : NARROW_PULSES;
  localparam int CNT_W      = $clog2(2 * MAX_PULSES + 3);
  localparam logic [CNT_W-1:0] WIDE_END   = CNT_W'(2 * WIDE_PULSES);
  localparam logic [CNT_W-1:0] NARROW_END = CNT_W'(2 * NARROW_PULSES);

  logic             busy;
  logic [CNT_W-1:0] tickCnt;
  logic             oddLine, wideLat, rightLat;
  logic [CNT_W-1:0] offset, phase, lastPhase;
  logic             inWindow;

  always_comb begin
    offset    = {{(CNT_W-1){1'b0}}, oddLine};
    phase     = tickCnt - offset;
    lastPhase = wideLat ? WIDE_END : NARROW_END;
    inWindow  = busy && (tickCnt >= offset);
    strobe.launch   = inWindow && (phase == '0);
    strobe.clkHigh  = inWindow && (phase != '0) && phase[0];
    strobe.oddLine  = oddLine;
    strobe.rightLat = rightLat;
    strobe.wideLat  = wideLat;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      tickCnt  <= '0;
      oddLine  <= 1'b0;
      wideLat  <= 1'b0;
      rightLat <= 1'b0;
    end else if (lineStart) begin
      busy     <= 1'b1;
      tickCnt  <= '0;
      oddLine  <= ~oddLine;
      wideLat  <= wideMode;
      rightLat <= rightScan;
    end else if (busy) begin
      if (inWindow && (phase == lastPhase)) begin
        busy <= 1'b0;
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

  // R7: parity inverts on each strobe
  p_parity_toggle_r7: assert property (@(posedge clk) disable iff (!rstN)
    lineStart |=> (strobe.oddLine != $past(strobe.oddLine)));

  // R9: captured modes hold between strobes
  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !lineStart |=> ($stable(strobe.wideLat) && $stable(strobe.rightLat)));

  // R3: counter never runs past the longest line
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (tickCnt <= CNT_W'(2 * MAX_PULSES + 1)));
endmodule

// File: rtl/hdrv_datapath.sv
module hdrv_datapath (
  input  logic clk,
  input  logic rstN,
  input  hdrv_pkg::hdrvStrobe_t strobe,
  output logic hStart,
  output logic hClkA,
  output logic hClkB,
  output logic linePolarity,
  output logic scanRight,
  output logic aspectWide
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hStart <= 1'b0;
      hClkA  <= 1'b0;
      hClkB  <= 1'b1;
    end else begin
      hStart <= strobe.launch;
      hClkA  <= strobe.clkHigh;
      hClkB  <= ~strobe.clkHigh;
    end
  end

  assign linePolarity = strobe.oddLine;
  assign scanRight    = strobe.rightLat;
  assign aspectWide   = strobe.wideLat;

  // R2: the two phases never agree
  p_complement_r2: assert property (@(posedge clk) disable iff (!rstN)
    hClkA != hClkB);

  // R5: start pulse lasts one tick
  p_start_width_r5: assert property (@(posedge clk) disable iff (!rstN)
    hStart |=> !hStart);

  // R5: first clock rise follows the start pulse directly
  p_start_then_clk_r5: assert property (@(posedge clk) disable iff (!rstN)
    hStart |=> hClkA);

  // R10: the clock is never high together with the start pulse
  p_start_clk_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    hStart |-> !hClkA);
endmodule

// File: rtl/hdrv_clkgen.sv
module hdrv_clkgen #(
  parameter int WIDE_PULSES   = 357,
  parameter int NARROW_PULSES = 268
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineStart,
  input  logic wideMode,
  input  logic rightScan,
  output logic hStart,
  output logic hClkA,
  output logic hClkB,
  output logic linePolarity,
  output logic scanRight,
  output logic aspectWide
);
  hdrv_pkg::hdrvStrobe_t strobe;

  hdrv_ctrl #(
    .WIDE_PULSES  (WIDE_PULSES),
    .NARROW_PULSES(NARROW_PULSES)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .lineStart(lineStart),
    .wideMode (wideMode),
    .rightScan(rightScan),
    .strobe   (strobe)
  );

  hdrv_datapath i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .hStart      (hStart),
    .hClkA       (hClkA),
    .hClkB       (hClkB),
    .linePolarity(linePolarity),
    .scanRight   (scanRight),
    .aspectWide  (aspectWide)
  );
endmodule

// File: tb/test_hdrv_clkgen.sv
module test_hdrv_clkgen;
  localparam int WIDE_N   = 357;
  localparam int NARROW_N = 268;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineStart = 1'b0;
  logic wideMode = 1'b0;
  logic rightScan = 1'b0;
  logic hStart, hClkA, hClkB, linePolarity, scanRight, aspectWide;

  int checks = 0;
  int errors = 0;
  logic expPol = 1'b0;

  always #10 clk = ~clk;

  hdrv_clkgen i_hdrv_clkgen (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .wideMode(wideMode),
    .rightScan(rightScan), .hStart(hStart), .hClkA(hClkA), .hClkB(hClkB),
    .linePolarity(linePolarity), .scanRight(scanRight), .aspectWide(aspectWide)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Strobe a line; returns just after edge E0
  task automatic strobeLine(input logic wide, input logic right);
    @(negedge clk);
    wideMode = wide; rightScan = right; lineStart = 1'b1;
    @(negedge clk);
    lineStart = 1'b0;
    expPol = ~expPol;
  endtask

  // Follow a line cycle by cycle; flipAt > 0 inverts the mode inputs then
  task automatic watchLine(input string tag, input int n, input logic wide,
                           input logic right, input int flipAt, input int stopAt);
    int startErr = 0, clkErr = 0, compErr = 0, modeErr = 0, rises = 0;
    int off = expPol ? 1 : 0;
    int last = (stopAt > 0) ? stopAt : 2 * n + 6;
    logic prevA = 1'b0;
    check(linePolarity == expPol, "R7 polarity", linePolarity, expPol);
    check(scanRight == right && aspectWide == wide, "R8 captured modes",
          {scanRight, aspectWide}, {right, wide});
    for (int i = 1; i <= last; i++) begin
      if (i == flipAt) begin
        wideMode = ~wideMode; rightScan = ~rightScan;
      end
      @(negedge clk);
      begin
        int j = i - off;
        logic eS = (j == 1);
        logic eA = (j >= 2) && (j <= 2 * n) && (j % 2 == 0);
        if (hStart != eS) startErr++;
        if (hClkA != eA) clkErr++;
        if (hClkB == hClkA) compErr++;
        if (scanRight != right || aspectWide != wide) modeErr++;
        if (hClkA && !prevA) rises++;
        prevA = hClkA;
      end
    end
    check(startErr == 0, {tag, " R5/R6 start position"}, startErr, 0);
    check(clkErr == 0, {tag, " R5/R6/R10 clock waveform"}, clkErr, 0);
    check(compErr == 0, {tag, " R2 complement"}, compErr, 0);
    check(modeErr == 0, {tag, " R9 modes held"}, modeErr, 0);
    if (stopAt == 0)
      check(rises == n, {tag, " R3/R4 pulse count"}, rises, n);
  endtask

  task automatic testReset();
    check(hStart == 0 && hClkA == 0 && hClkB == 1, "R1 reset clocks",
          {hStart, hClkA, hClkB}, 3'b001);
    check(linePolarity == 0 && scanRight == 0 && aspectWide == 0, "R1 reset flags",
          {linePolarity, scanRight, aspectWide}, 0);
  endtask

  task automatic testIdle();
    int bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (hStart || hClkA || !hClkB) bad++;
    end
    check(bad == 0, "R10 idle between lines", bad, 0);
  endtask

  task automatic testWideRight();
    strobeLine(1'b1, 1'b1);
    watchLine("wide-right odd R3", WIDE_N, 1'b1, 1'b1, 0, 0);
  endtask

  task automatic testNarrowLeft();
    strobeLine(1'b0, 1'b0);
    watchLine("narrow-left even R4", NARROW_N, 1'b0, 1'b0, 0, 0);
  endtask

  task automatic testNarrowRightOdd();
    strobeLine(1'b0, 1'b1);
    watchLine("narrow-right odd R6", NARROW_N, 1'b0, 1'b1, 0, 0);
  endtask

  task automatic testWideLeftFlip();
    strobeLine(1'b1, 1'b0);
    watchLine("wide-left flip R9", WIDE_N, 1'b1, 1'b0, 30, 0);
  endtask

  task automatic testRestart();
    strobeLine(1'b1, 1'b1);
    watchLine("abandoned R11", WIDE_N, 1'b1, 1'b1, 0, 40);
    strobeLine(1'b0, 1'b1);
    watchLine("restarted R11", NARROW_N, 1'b0, 1'b1, 0, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
        testReset();
        testIdle();
        testWideRight();
        testIdle();
        testNarrowLeft();
        testNarrowRightOdd();
        testWideLeftFlip();
        testIdle();
        testRestart();
        testIdle();
      end
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule